// File: doc/BRIEF.md
# Sub-Word Register Access Bridge

This block lets a host bus that issues byte, halfword and word register accesses talk to a peripheral register file that only takes aligned 32-bit reads and writes. A narrow read fetches the containing word and returns the addressed lane, zero-extended. A narrow write becomes a read-modify-write of the containing word. Word accesses go straight through.

One word of the peripheral holds two 16-bit fields: a transfer-mode field in its low half and a command field in its high half. The peripheral must see both halves in a single word write. The bridge keeps a shadow of that word. A halfword write to the transfer-mode half only updates the shadow. A halfword write to the command half merges with the shadow and goes out as one word write. Halfword reads of either half are served from the shadow.

The peripheral loses writes that come too close together in its card-clock domain. After any peripheral write, the bridge therefore holds off the next one until the card clock has ticked a set number of times. The hold-off applies only while the card clock runs. The host handshake is valid/ready, and read data comes back on a one-cycle response strobe.

Top module: `subword_reg_bridge`

## Requirements
- R1: A byte read (h_size=0) returns, in h_rdata[7:0] with zeros above, bits [8*a+7:8*a] of the word at address h_addr with bits [1:0] cleared, where a = h_addr[1:0].
- R2: A byte write reads the containing word, replaces only byte lane h_addr[1:0] with h_wdata[7:0], and writes the whole word back in the next cycle. h_ready is low during the write-back cycle.
- R3: A halfword access (h_size=1) outside the shadow halves uses lane h_addr[1] (bits [31:16] when 1, [15:0] when 0), and h_addr[0] is ignored. A read returns that lane zero-extended. A write is a read-modify-write of that lane only.
- R4: A halfword write to the transfer-mode half (byte offset XFER_OFS, default 0x0C) sets shadow[15:0] to h_wdata[15:0] and issues no peripheral read or write.
- R5: A halfword write to the command half (byte offset CMD_OFS, default 0x0E) issues exactly one peripheral write of {h_wdata[15:0], shadow[15:0]} to the aligned word, with no peripheral read, and keeps that word as the new shadow.
- R6: Halfword reads of the transfer-mode and command halves return shadow[15:0] and shadow[31:16] and issue no peripheral read. Byte and word accesses to that word reach the peripheral and leave the shadow unchanged.
- R7: Word accesses (h_size=2 or 3) read or write the aligned word unchanged.
- R8: While card_clk_on is high, a peripheral write is separated from the previous one by at least GAP_TICKS card_tick pulses (default 2) arriving after the earlier write's clock edge. h_ready is low during the hold-off.
- R9: While card_clk_on is low there is no hold-off. Dropping card_clk_on in the middle of a hold-off releases h_ready at once.
- R10: After reset the shadow is zero, h_ready is high and h_rvalid is low.
- R11: h_rvalid pulses for one cycle, in the cycle after a read is accepted, with its data in h_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| h_addr | input | AW | Host byte address |
| h_wdata | input | 32 | Write value, narrow values in the low bits |
| h_rvalid | output | 1 | Read response strobe |
| h_rdata | output | 32 | Read response data |
| p_rd_en | output | 1 | Peripheral word read, data taken in the same cycle |
| p_wr_en | output | 1 | Peripheral word write |
| p_addr | output | AW | Word-aligned peripheral address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data |
| card_tick | input | 1 | One pulse per card-clock period |
| card_clk_on | input | 1 | Card clock is running |

## Verification
The bench sweeps every lane of every word with byte and halfword writes. Each write is followed by a word readback, so a merge that disturbs a neighbouring lane shows up as a miscompare. Lane indexing is checked with byte and halfword reads across all offsets. An extractor that shifted by the wrong amount would return the wrong byte.

The shadow sequence checks three things. It confirms that a transfer-mode write leaves the peripheral word and the peripheral write count unchanged, which catches a design that issued it early. It confirms that the command write carries the stored low half, which catches a design that refetched the word from the peripheral. It confirms that shadow reads do not increase the read count.

An independent monitor measures card_tick pulses between peripheral writes while the card clock runs. Separate checks stop the card clock and confirm that h_ready is released, so a timer that ignored the run signal would stall the host.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WBACK = 1'b1
  } brg_state_e;

  // Pull the addressed lane out of a word, zero-extended.
  function automatic logic [31:0] lane_get(input logic [31:0] w,
                                           input logic [1:0]  lo,
                                           input acc_size_e   sz);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {24'd0, w[{lo, 3'b000} +: 8]};
      SZ_HALF: r = {16'd0, w[{lo[1], 4'b0000} +: 16]};
      default: r = w;
    endcase
    return r;
  endfunction

  // Replace the addressed lane of a word with the low bits of nv.
  function automatic logic [31:0] lane_put(input logic [31:0] old,
                                           input logic [31:0] nv,
                                           input logic [1:0]  lo,
                                           input acc_size_e   sz);
    logic [31:0] r;
    r = old;
    case (sz)
      SZ_BYTE: r[{lo, 3'b000} +: 8] = nv[7:0];
      SZ_HALF: r[{lo[1], 4'b0000} +: 16] = nv[15:0];
      default: r = nv;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sb_lane_unit.sv
module sb_lane_unit
  import sb_pkg::*;
(
  input  logic [31:0] word_in,
  input  logic [31:0] wr_val,
  input  logic [1:0]  lo,
  input  acc_size_e   sz,
  output logic [31:0] lane_rd,
  output logic [31:0] merged
);

  always_comb begin
    lane_rd = lane_get(word_in, lo, sz);
    merged  = lane_put(word_in, wr_val, lo, sz);
  end

endmodule

// File: rtl/sb_gap_timer.sv
module sb_gap_timer #(
  parameter int GAP_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic tick,
  input  logic clk_on,
  output logic busy
);

  localparam int CW = $clog2(GAP_TICKS + 1);

  logic [CW-1:0] cnt;
  logic          cnt_nz;
  logic          tick_hit;

  assign cnt_nz   = (cnt != '0);
  assign tick_hit = tick && cnt_nz;
  assign busy     = cnt_nz && clk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!clk_on)    cnt <= '0;
    else if (wr_fire)    cnt <= CW'(GAP_TICKS);
    else if (tick_hit)   cnt <= cnt - 1'b1;
  end

  // R8: without a tick or a new write the remaining gap holds
  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_on && !tick && !wr_fire) |=> (cnt == $past(cnt)));

  // R9: a stopped card clock leaves no pending gap
  p_gap_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on) |=> (cnt == '0));

endmodule

// File: rtl/sb_shadow.sv
module sb_shadow (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic [15:0] din,
  output logic [31:0] shadow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else begin
      if (ld_lo) shadow[15:0]  <= din;
      if (ld_hi) shadow[31:16] <= din;
    end
  end

  // R4/R5: a half not loaded keeps its value
  p_shadow_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_lo && !ld_hi) |=> (shadow == $past(shadow)));

endmodule

// File: rtl/subword_reg_bridge.sv
module subword_reg_bridge
  import sb_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          GAP_TICKS = 2,
  parameter logic [31:0] XFER_OFS  = 32'h0000_000C,
  parameter logic [31:0] CMD_OFS   = 32'h0000_000E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_write,
  input  logic [1:0]    h_size,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic          h_rvalid,
  output logic [31:0]   h_rdata,
  output logic          p_rd_en,
  output logic          p_wr_en,
  output logic [AW-1:0] p_addr,
  output logic [31:0]   p_wdata,
  input  logic [31:0]   p_rdata,
  input  logic          card_tick,
  input  logic          card_clk_on
);

  localparam int WAW = AW - 2;
  localparam logic [WAW-1:0] SH_WORD = XFER_OFS[AW-1:2];
  localparam logic           XFER_HI = XFER_OFS[1];
  localparam logic           CMD_HI  = CMD_OFS[1];

  brg_state_e    state;
  acc_size_e     sz;
  logic          acc;
  logic          gap_busy;
  logic [AW-1:0] word_addr;
  logic          in_sh_word;
  logic          xfer_hit;
  logic          cmd_hit;
  logic          sh_read;
  logic          xfer_wr;
  logic          cmd_wr;
  logic          narrow_wr;
  logic [31:0]   shadow;
  logic [31:0]   lane_rd;
  logic [31:0]   merged;
  logic [31:0]   rmw_word;
  logic [AW-1:0] rmw_addr;
  logic [31:0]   rd_next;

  assign sz         = acc_size_e'(h_size);
  assign h_ready    = (state == ST_IDLE) && !gap_busy;
  assign acc        = h_valid && h_ready;
  assign word_addr  = {h_addr[AW-1:2], 2'b00};
  assign in_sh_word = (h_addr[AW-1:2] == SH_WORD);
  assign xfer_hit   = (sz == SZ_HALF) && in_sh_word && (h_addr[1] == XFER_HI);
  assign cmd_hit    = (sz == SZ_HALF) && in_sh_word && (h_addr[1] == CMD_HI);
  assign sh_read    = acc && !h_write && (xfer_hit || cmd_hit);
  assign xfer_wr    = acc && h_write && xfer_hit;
  assign cmd_wr     = acc && h_write && cmd_hit && !xfer_hit;
  assign narrow_wr  = acc && h_write && !xfer_hit && !cmd_hit
                      && ((sz == SZ_BYTE) || (sz == SZ_HALF));

  sb_lane_unit u_lane (
    .word_in (p_rdata),
    .wr_val  (h_wdata),
    .lo      (h_addr[1:0]),
    .sz      (sz),
    .lane_rd (lane_rd),
    .merged  (merged)
  );

  sb_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_lo  (xfer_wr),
    .ld_hi  (cmd_wr),
    .din    (h_wdata[15:0]),
    .shadow (shadow)
  );

  sb_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (p_wr_en),
    .tick    (card_tick),
    .clk_on  (card_clk_on),
    .busy    (gap_busy)
  );

  // Peripheral side decode
  always_comb begin
    p_rd_en = 1'b0;
    p_wr_en = 1'b0;
    p_addr  = word_addr;
    p_wdata = h_wdata;
    if (state == ST_WBACK) begin
      p_wr_en = 1'b1;
      p_addr  = rmw_addr;
      p_wdata = rmw_word;
    end else if (acc) begin
      if (!h_write) begin
        p_rd_en = !sh_read;
      end else if (cmd_wr) begin
        p_wr_en = 1'b1;
        p_wdata = {h_wdata[15:0], shadow[15:0]};
      end else if (narrow_wr) begin
        p_rd_en = 1'b1;
      end else if (!xfer_wr) begin
        p_wr_en = 1'b1;
      end
    end
  end

  // Read response value
  always_comb begin
    rd_next = lane_rd;
    if (sh_read) rd_next = (h_addr[1] == CMD_HI) ? {16'd0, shadow[31:16]}
                                                 : {16'd0, shadow[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rmw_word <= '0;
      rmw_addr <= '0;
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= acc && !h_write;
      if (acc && !h_write) h_rdata <= rd_next;
      case (state)
        ST_IDLE: if (narrow_wr) begin
          state    <= ST_WBACK;
          rmw_word <= merged;
          rmw_addr <= word_addr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: no peripheral write while the card-clock gap is pending
  p_wr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_en |-> !gap_busy);

  // R2: write-back cycle follows a narrow write and blocks the host
  p_rmw_wback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_wr |=> (p_wr_en && !h_ready && p_addr == $past(word_addr)));

  // R4: transfer-mode write stays off the peripheral
  p_xfer_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wr |-> (!p_wr_en && !p_rd_en));

  // R5: command write carries the stored low half
  p_cmd_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (p_wr_en && !p_rd_en && p_wdata[15:0] == shadow[15:0]));

  // R5: after a command write the shadow equals what was written
  p_cmd_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (shadow == $past(p_wdata)));

  // R11: one response per accepted read, in the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !h_write) |=> h_rvalid);

  p_rvalid_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !h_write) |=> !h_rvalid);

  // R6: shadow reads never reach the peripheral
  p_sh_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sh_read |-> !p_rd_en);

  // at most one peripheral operation per cycle
  p_one_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p_rd_en, p_wr_en}));

endmodule

// File: tb/subword_reg_bridge_bench.sv
module subword_reg_bridge_bench;

  localparam int AW   = 5;
  localparam int NW   = 8;
  localparam int TDIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_valid = 1'b0;
  logic          h_ready;
  logic          h_write = 1'b0;
  logic [1:0]    h_size = 2'd2;
  logic [AW-1:0] h_addr = '0;
  logic [31:0]   h_wdata = '0;
  logic          h_rvalid;
  logic [31:0]   h_rdata;
  logic          p_rd_en, p_wr_en;
  logic [AW-1:0] p_addr;
  logic [31:0]   p_wdata;
  logic [31:0]   p_rdata;
  logic          card_tick = 1'b0;
  logic          card_clk_on = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int n_prd = 0;
  int n_pwr = 0;
  int tdiv_cnt = 0;
  int ticks_since = 0;
  bit armed = 1'b0;

  logic [31:0] pmem [NW];
  logic [31:0] ref_mem [NW];
  logic [31:0] ref_sh = '0;

  always #10 clk = ~clk;

  subword_reg_bridge #(.AW(AW), .GAP_TICKS(2)) u_subword_reg_bridge (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .p_rd_en(p_rd_en),
    .p_wr_en(p_wr_en), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdata(p_rdata), .card_tick(card_tick), .card_clk_on(card_clk_on));

  assign p_rdata = pmem[p_addr[4:2]];

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // card-clock tick generator
  always @(negedge clk) begin
    tdiv_cnt  = (tdiv_cnt + 1) % TDIV;
    card_tick = (tdiv_cnt == 0);
  end

  // peripheral model and write-spacing monitor (R8)
  always @(posedge clk) begin
    if (p_rd_en) n_prd++;
    if (!card_clk_on) armed = 1'b0;
    if (card_tick && card_clk_on) ticks_since++;
    if (p_wr_en) begin
      pmem[p_addr[4:2]] <= p_wdata;
      n_pwr++;
      n_vec++;
      if (armed && ticks_since < 2) begin
        n_bad++;
        $display("FAIL R8 write spacing actual=%0d ticks expected>=2", ticks_since);
      end
      armed = card_clk_on;
      ticks_since = 0;
    end
  end

  task automatic host_op(input logic wr, input logic [1:0] sz,
                         input logic [AW-1:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_size = sz; h_addr = a; h_wdata = d;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    h_valid = 1'b0;
    rd = h_rdata;
    if (!wr) check("R11 rvalid after read", {31'd0, h_rvalid}, 32'd1);
  endtask

  function automatic logic [31:0] pick(input int w, input int l, input int k);
    return 32'(((w * 37 + l * 11 + k * 5) & 255) ^ 8'h5A)
         | (32'(((w * 13 + l * 29 + k) & 255)) << 8);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int p0;
    for (int i = 0; i < NW; i++) begin
      pmem[i]    = 32'hC3A5_0F00 ^ (32'(i) * 32'h0101_0107);
      ref_mem[i] = 32'hC3A5_0F00 ^ (32'(i) * 32'h0101_0107);
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ready after reset", {31'd0, h_ready}, 32'd1);
    check("R10 rvalid after reset", {31'd0, h_rvalid}, 32'd0);
    rst_n = 1'b1;
    host_op(1'b0, 2'd1, 5'h0C, 32'd0, rd);
    check("R10 shadow low zero", rd, 32'd0);
    host_op(1'b0, 2'd1, 5'h0E, 32'd0, rd);
    check("R10 shadow high zero", rd, 32'd0);

    // R7: word reads of every word
    for (int w = 0; w < NW; w++) begin
      host_op(1'b0, 2'd2, 5'(w * 4), 32'd0, rd);
      check("R7 word read", rd, ref_mem[w]);
    end
    // R1: byte reads over every lane
    for (int w = 0; w < NW; w++)
      for (int l = 0; l < 4; l++) begin
        host_op(1'b0, 2'd0, 5'(w * 4 + l), 32'd0, rd);
        check("R1 byte read", rd, (ref_mem[w] >> (8 * l)) & 32'hFF);
      end
    // R2: byte writes over every lane, each with word readback
    for (int w = 0; w < NW; w++)
      for (int l = 0; l < 4; l++) begin
        logic [31:0] v;
        v = pick(w, l, 1) | 32'hFFFF_FF00;
        host_op(1'b1, 2'd0, 5'(w * 4 + l), v, rd);
        ref_mem[w] = (ref_mem[w] & ~(32'hFF << (8 * l))) | ((v & 32'hFF) << (8 * l));
        host_op(1'b0, 2'd2, 5'(w * 4), 32'd0, rd);
        check("R2 byte write merge", rd, ref_mem[w]);
      end
    // R3: halfword writes/reads outside shadow, all four offsets
    for (int w = 0; w < NW; w++) begin
      if (w == 3) continue;
      for (int l = 0; l < 4; l++) begin
        logic [31:0] v;
        int hs;
        hs = (l / 2) * 16;
        v = pick(w, l, 2) | 32'hABCD_0000;
        host_op(1'b1, 2'd1, 5'(w * 4 + l), v, rd);
        ref_mem[w] = (ref_mem[w] & ~(32'hFFFF << hs)) | ((v & 32'hFFFF) << hs);
        host_op(1'b0, 2'd2, 5'(w * 4), 32'd0, rd);
        check("R3 half write merge", rd, ref_mem[w]);
        host_op(1'b0, 2'd1, 5'(w * 4 + (l ^ 1)), 32'd0, rd);
        check("R3 half read", rd, (ref_mem[w] >> hs) & 32'hFFFF);
      end
    end

    // R4: transfer-mode half goes to shadow only
    p0 = n_pwr;
    host_op(1'b1, 2'd1, 5'h0C, 32'h7777_BEEF, rd);
    check("R4 no peripheral write", 32'(n_pwr - p0), 32'd0);
    host_op(1'b0, 2'd2, 5'h0C, 32'd0, rd);
    check("R4 peripheral word untouched", rd, ref_mem[3]);
    p0 = n_prd;
    host_op(1'b0, 2'd1, 5'h0C, 32'd0, rd);
    check("R6 shadow low read", rd, 32'h0000_BEEF);
    host_op(1'b0, 2'd1, 5'h0E, 32'd0, rd);
    check("R6 shadow high read", rd, 32'd0);
    check("R6 no peripheral read", 32'(n_prd - p0), 32'd0);
    // R5: command half commits both halves
    p0 = n_pwr;
    host_op(1'b1, 2'd1, 5'h0E, 32'h0000_1234, rd);
    ref_mem[3] = 32'h1234_BEEF;
    @(negedge clk);
    check("R5 one peripheral write", 32'(n_pwr - p0), 32'd1);
    host_op(1'b0, 2'd2, 5'h0C, 32'd0, rd);
    check("R5 merged word", rd, 32'h1234_BEEF);
    host_op(1'b1, 2'd1, 5'h0C, 32'h0000_5555, rd);
    host_op(1'b1, 2'd1, 5'h0F, 32'h0000_AAAA, rd);
    host_op(1'b0, 2'd2, 5'h0C, 32'd0, rd);
    check("R5 second merge", rd, 32'hAAAA_5555);
    ref_mem[3] = 32'hAAAA_5555;
    host_op(1'b0, 2'd1, 5'h0E, 32'd0, rd);
    check("R5 shadow kept", rd, 32'h0000_AAAA);
    // R6: byte write on shadow word hits peripheral, shadow intact
    host_op(1'b1, 2'd0, 5'h0D, 32'h0000_0042, rd);
    ref_mem[3] = 32'hAAAA_4255;
    host_op(1'b0, 2'd2, 5'h0C, 32'd0, rd);
    check("R6 byte write reaches peripheral", rd, ref_mem[3]);
    host_op(1'b0, 2'd1, 5'h0C, 32'd0, rd);
    check("R6 shadow unaffected", rd, 32'h0000_5555);

    // R8: hold-off after a word write
    card_clk_on = 1'b1;
    host_op(1'b1, 2'd2, 5'h10, 32'h0BAD_F00D, rd);
    ref_mem[4] = 32'h0BAD_F00D;
    check("R8 ready low after write", {31'd0, h_ready}, 32'd0);
    for (int k = 0; k < 6; k++) begin
      host_op(1'b1, 2'd2, 5'(4 * (k % 3)), 32'h1100_0000 + 32'(k), rd);
      ref_mem[k % 3] = 32'h1100_0000 + 32'(k);
    end
    // R9: stopping the card clock releases the hold-off
    host_op(1'b1, 2'd2, 5'h14, 32'h5A5A_0001, rd);
    ref_mem[5] = 32'h5A5A_0001;
    check("R9 held while clock on", {31'd0, h_ready}, 32'd0);
    card_clk_on = 1'b0;
    #1;
    check("R9 released when clock stops", {31'd0, h_ready}, 32'd1);
    host_op(1'b1, 2'd2, 5'h18, 32'h5A5A_0002, rd);
    ref_mem[6] = 32'h5A5A_0002;
    check("R9 no gap with clock off", {31'd0, h_ready}, 32'd1);
    host_op(1'b1, 2'd0, 5'h1B, 32'h0000_0099, rd);
    ref_mem[6] = 32'h995A_0002;
    card_clk_on = 1'b1;
    // R7: final readback of every word
    for (int w = 0; w < NW; w++) begin
      host_op(1'b0, 2'd3, 5'(w * 4 + 1), 32'd0, rd);
      check("R7 final word", rd, ref_mem[w]);
    end
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule